// File: doc/BRIEF.md
# Serial Word-Memory Command Front-End

This block is the target side of a three-wire serial link to a small word-addressed memory of 64 words of 16 bits. A master raises select, toggles a serial clock and shifts bits in on a data line; the block hunts for a start bit and collects a 2-bit opcode and a 6-bit address, MSB first. Depending on the decoded instruction it then takes a 16-bit data word, changes its write-enable latch, or streams read data back on a data-out line that has its own output enable.

Instructions come from the opcode, the top two address bits and two side-band pins. One pin directs the instruction to the protect register instead of the array. The other pin allows operations that modify storage. A read keeps streaming consecutive words for as long as select stays high. Protect-register instructions have no effect on the array or on data-out here; protection checking and programming delays are handled by other blocks. The storage is plain registers, cleared at reset.

The serial clock, data and select inputs are sampled with the system clock. A serial clock edge takes effect at the first system clock edge where the sampled serial clock is high and was low before.

Top module: `sermem_front`

## Requirements
- R1: Zeros clocked in while waiting for a start bit are ignored. The first 1 is taken as the start bit.
- R2: After the start bit, the next two bits form the opcode and the six bits after those form the address. Both fields are sent MSB first.
- R3: Opcode 10 with protect-select low is a read. On the serial clock edge that takes in the last address bit, data-out goes to 0 (a dummy bit) with the output enable high. Each later rising edge then drives one data bit, starting with bit 15.
- R4: Opcode 01 with protect-select low is a write. It takes 16 data bits, bit 15 first. The word is stored at the address when the last bit arrives, if the enable latch is set and the write-enable pin is high.
- R5: A read returns stored data whatever the level of the write-enable pin.
- R6: While select stays high, a read continues after bit 0 of a word with bit 15 of the next address. The address wraps from 63 to 0.
- R7: The enable latch is set by opcode 00 with A5:A4 = 11, and cleared by opcode 00 with A5:A4 = 00 and by reset. No storage changes while the latch is clear or while the write-enable pin is low.
- R8: When protect-select is high, no instruction changes the array and data-out stays disabled.
- R9: The data-out enable is low while select is low and at all times when no read data is being streamed.
- R10: Opcode 00 with A5:A4 = 01 is write-all. It takes 16 data bits and, under the same enable conditions as R4, writes that value to every word.
- R11: Dropping select aborts any instruction in progress. The next cycle starts again by hunting for a start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sel | input | 1 | Select from the master, active high |
| sclk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data in |
| prot_sel | input | 1 | High directs instructions to the protect register |
| wr_en_pin | input | 1 | High allows operations that modify storage |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |

## Verification
The assertions assume that select, serial clock and the side-band pins are synchronous to the system clock and stay stable for several system clocks around each serial clock edge. They also assume that protect-select does not change in the middle of an instruction. The bench drives every input on the falling system clock edge. It holds each serial clock level for several system clocks and changes protect-select or the write-enable pin only while select is low. Every data-out sample is taken a few system clocks after the rising serial clock edge that produced it.

// File: rtl/sermem_front.sv
module sermem_front #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic sclk,
  input  logic sdi,
  input  logic prot_sel,
  input  logic wr_en_pin,
  output logic sdo,
  output logic sdo_oe
);
  localparam int WORDS = 1 << AW;
  localparam int CW = $clog2(DW) + 1;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DATA, S_RD, S_HOLD} st_t;

  st_t st;
  logic sclk_q, rise, all_q, wen_q;
  logic [CW-1:0] cnt;
  logic [AW+1:0] hdr;
  logic [AW+1:0] nxt;
  logic [AW-1:0] addr;
  logic [DW-1:0] dat, obuf;
  logic [DW-1:0] word;
  logic [WORDS-1:0][DW-1:0] mem;

  assign rise = sclk & ~sclk_q;
  assign nxt  = {hdr[AW:0], sdi};
  assign word = {dat[DW-2:0], sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; hdr <= '0; addr <= '0; dat <= '0; obuf <= '0;
      sdo <= 1'b0; sdo_oe <= 1'b0; all_q <= 1'b0; wen_q <= 1'b0; mem <= '0;
    end else if (!sel) begin
      st <= S_IDLE; cnt <= '0; sdo <= 1'b0; sdo_oe <= 1'b0;
    end else if (rise) begin
      case (st)
        S_IDLE: if (sdi) begin st <= S_HDR; cnt <= '0; end
        S_HDR: begin
          hdr <= nxt;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(AW + 1)) begin
            cnt <= '0;
            st  <= S_HOLD;
            if (!prot_sel) begin
              case (nxt[AW+1:AW])
                2'b10: begin
                  st <= S_RD; addr <= nxt[AW-1:0]; obuf <= mem[nxt[AW-1:0]];
                  sdo <= 1'b0; sdo_oe <= 1'b1;
                end
                2'b01: begin st <= S_DATA; addr <= nxt[AW-1:0]; all_q <= 1'b0; end
                2'b00: begin
                  case (nxt[AW-1:AW-2])
                    2'b11: wen_q <= 1'b1;
                    2'b00: wen_q <= 1'b0;
                    2'b01: begin st <= S_DATA; all_q <= 1'b1; end
                    default: ;
                  endcase
                end
                default: ;
              endcase
            end
          end
        end
        S_DATA: begin
          dat <= word;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(DW - 1)) begin
            st <= S_HOLD;
            if (wen_q && wr_en_pin && !prot_sel) begin
              if (all_q) mem <= {WORDS{word}};
              else       mem[addr] <= word;
            end
          end
        end
        S_RD: begin
          sdo  <= obuf[DW-1];
          obuf <= obuf << 1;
          cnt  <= cnt + 1'b1;
          if (cnt == CW'(DW - 1)) begin
            cnt  <= '0;
            addr <= addr + 1'b1;
            obuf <= mem[addr + 1'b1];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sermem_front_chk.sv
module sermem_front_chk #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input logic clk,
  input logic rst_n,
  input logic sel,
  input logic pe,
  input logic prot,
  input logic sdo,
  input logic sdo_oe,
  input logic wen_q,
  input logic [(1<<AW)-1:0][DW-1:0] mem
);
  a_r9_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !sdo_oe);
  a_r3_dummy_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !sdo);
  a_r7_locked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wen_q |=> $stable(mem));
  a_r7_pe_low_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !pe |=> $stable(mem));
  a_r8_protsel_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    prot |=> $stable(mem));
endmodule

bind sermem_front sermem_front_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .pe(wr_en_pin), .prot(prot_sel),
  .sdo(sdo), .sdo_oe(sdo_oe), .wen_q(wen_q), .mem(mem)
);

// File: tb/sermem_front_tb.sv
module sermem_front_tb;
  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic prot_sel = 1'b0, wr_en_pin = 1'b1;
  logic sdo, sdo_oe;
  int checks = 0, errors = 0;
  logic [15:0] mdl [64];
  logic mwen = 1'b0;
  logic expq [$];
  string cur_req = "R3";
  event smp;

  sermem_front u_dut (.clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdi(sdi),
    .prot_sel(prot_sel), .wr_en_pin(wr_en_pin), .sdo(sdo), .sdo_oe(sdo_oe));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(smp) begin
    logic e;
    e = expq.pop_front();
    chk(sdo_oe === 1'b1 && sdo === e, cur_req, {sdo_oe, sdo}, {1'b1, e});
  end

  task automatic bit_(input logic b, input bit sample);
    @(negedge clk) sdi = b;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    if (sample) -> smp;
    sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic hdr(input logic [1:0] op, input logic [5:0] a, input int lead, input bit last_sample);
    @(negedge clk) sel = 1'b1;
    for (int i = 0; i < lead; i++) bit_(1'b0, 0);
    bit_(1'b1, 0);
    bit_(op[1], 0); bit_(op[0], 0);
    for (int i = 5; i >= 1; i--) bit_(a[i], 0);
    bit_(a[0], last_sample);
  endtask

  task automatic end_cyc;
    @(negedge clk) sel = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic write_word(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d);
    hdr(op, a, 0, 0);
    for (int i = 15; i >= 0; i--) bit_(d[i], 0);
    end_cyc();
    if (mwen && wr_en_pin && !prot_sel) begin
      if (op == 2'b00) for (int k = 0; k < 64; k++) mdl[k] = d;
      else mdl[a] = d;
    end
  endtask

  task automatic cmd(input logic [5:0] a);
    hdr(2'b00, a, 0, 0);
    end_cyc();
    if (a[5:4] == 2'b11) mwen = 1'b1;
    if (a[5:4] == 2'b00) mwen = 1'b0;
  endtask

  task automatic read_words(input logic [5:0] a, input int n, input int lead, input string req);
    logic [5:0] p;
    cur_req = req;
    expq.push_back(1'b0);
    hdr(2'b10, a, lead, 1);
    p = a;
    for (int w = 0; w < n; w++) begin
      for (int i = 15; i >= 0; i--) begin
        expq.push_back(mdl[p][i]);
        bit_(1'b0, 1);
      end
      p = p + 6'd1;
    end
    end_cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 64; k++) mdl[k] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sdo_oe === 1'b0, "R9 reset", sdo_oe, 0);

    write_word(2'b01, 6'd5, 16'hBEEF);
    read_words(6'd5, 1, 0, "R7 locked write");

    cmd(6'b110000);
    write_word(2'b01, 6'd5, 16'hA5C3);
    read_words(6'd5, 1, 0, "R4 write/R2/R3 read");
    read_words(6'd5, 1, 3, "R1 leading zeros");

    write_word(2'b01, 6'd62, 16'h1357);
    write_word(2'b01, 6'd63, 16'hFACE);
    write_word(2'b01, 6'd0, 16'h8001);
    read_words(6'd62, 3, 0, "R6 sequential wrap");

    wr_en_pin = 1'b0;
    write_word(2'b01, 6'd62, 16'h0F0F);
    read_words(6'd62, 1, 0, "R5 read with pin low / R7 pin low");
    wr_en_pin = 1'b1;

    prot_sel = 1'b1;
    write_word(2'b01, 6'd63, 16'h7777);
    hdr(2'b10, 6'd63, 0, 0);
    bit_(1'b0, 0);
    chk(sdo_oe === 1'b0, "R8 protect read no output", sdo_oe, 0);
    end_cyc();
    prot_sel = 1'b0;
    read_words(6'd63, 1, 0, "R8 protect write ignored");

    hdr(2'b10, 6'd5, 0, 0);
    bit_(1'b0, 0); bit_(1'b0, 0);
    @(negedge clk) sel = 1'b0;
    repeat (2) @(negedge clk);
    chk(sdo_oe === 1'b0, "R9/R11 deselect", sdo_oe, 0);
    repeat (2) @(negedge clk);
    read_words(6'd5, 1, 0, "R11 fresh cycle");

    hdr(2'b01, 6'd9, 0, 0);
    bit_(1'b1, 0);
    chk(sdo_oe === 1'b0, "R9 no output during write", sdo_oe, 0);
    end_cyc();

    write_word(2'b00, 6'b010000, 16'h2468);
    read_words(6'd20, 2, 0, "R10 write all");

    cmd(6'b000000);
    write_word(2'b01, 6'd20, 16'h9999);
    read_words(6'd20, 1, 0, "R7 after disable");

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule